// File: doc/BRIEF.md
# Dual-Clock FIFO with Almost-Full and Almost-Empty Flags

This block carries 36-bit words from a port A clock domain into a port B clock domain through 64 words of storage. Each port samples four access strobes on its own clock: an active-low select, a direction level, a mailbox level and an active-high enable. A port A edge with the write pattern stores the word on `a_din`. A port B edge with the read pattern loads the oldest stored word into the port B output register. That register keeps its value until the next accepted read.

The write side shows space-available and almost-full indications. The read side shows data-available and almost-empty indications. Both almost thresholds are measured against a static offset `ALMOST_OFS`. The two pointers cross domains as Gray codes through two-flop synchronizers, and each side computes its flags only from its own pointer and the synchronized copy of the other pointer. A pointer change therefore reaches the opposite side's flags a few edges later. The exact number of edges depends on how the two clocks are skewed. The late clearing is always on the safe side.

Each side holds its fill level in a small enumerated state register. The write side has three states: `WR_OPEN` (below the almost-full mark), `WR_HIGH` (at or above the mark, not full) and `WR_FULL` (all words used). The read side has three states: `RD_EMPTY` (no words), `RD_LOW` (one to `ALMOST_OFS` words) and `RD_OPEN` (more than `ALMOST_OFS` words). On each edge the state moves to whichever level the freshly computed fill selects. Any state can go to any other: the level can rise by one through a local access, or jump when the synchronized pointer catches up. A separate process decodes the output flags from the state.

Top module: `xdom_fifo`

## Requirements
- R1: A word is stored on a rising `clk_a` edge only when `a_cs_n`=0, `a_wr`=1, `a_mbx`=0 and `a_en`=1 and `a_room` is 1; any other pattern stores nothing.
- R2: A read happens on a rising `clk_b` edge only when `b_cs_n`=0, `b_wr`=0, `b_mbx`=0 and `b_en`=1 and `b_avail` is 1; any other pattern leaves the output and the stored words untouched.
- R3: `a_room` is 0 exactly when the write side sees all `DEPTH` words in use (its own writes minus the synchronized read count); a write that fills the last word clears `a_room` at that same edge.
- R4: `b_avail` is 0 exactly when the read side sees no stored word (synchronized write count minus its own reads).
- R5: `b_almost_empty` is 1 while the read side sees `ALMOST_OFS` words or fewer, and 0 once it sees `ALMOST_OFS`+1 or more.
- R6: `a_almost_full` is 1 while the write side sees `DEPTH`-`ALMOST_OFS` words or more, and 0 once it sees `DEPTH`-`ALMOST_OFS`-1 or fewer.
- R7: Words leave in the order they were written; `b_dout` changes only on an accepted read and otherwise keeps the last word read.
- R8: A write attempt while `a_room` is 0 is dropped and does not disturb the stored words.
- R9: A read attempt while `b_avail` is 0 is ignored; `b_dout` keeps its value.
- R10: Asserting `rst_n` low empties the FIFO at once: `a_room`=1, `a_almost_full`=0, `b_avail`=0, `b_almost_empty`=1, `b_dout`=0.
- R11: A pointer change in one domain reaches the other domain's flags at the third rising edge of that domain's clock that follows it (two synchronizer stages and the flag register) when no edges coincide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_mbx | input | 1 | Port A mailbox level, must be 0 for FIFO access |
| a_en | input | 1 | Port A enable, active high |
| a_din | input | WIDTH | Word to store |
| a_room | output | 1 | Space available (0 = full) |
| a_almost_full | output | 1 | Fill at or above DEPTH-ALMOST_OFS |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr | input | 1 | Port B direction, 0 = read |
| b_mbx | input | 1 | Port B mailbox level, must be 0 for FIFO access |
| b_en | input | 1 | Port B enable, active high |
| b_dout | output | WIDTH | Port B output register |
| b_avail | output | 1 | Data available (0 = empty) |
| b_almost_empty | output | 1 | Fill at or below ALMOST_OFS |

## Verification
The bench builds the block with its default shape: 64 words of 36 bits and an offset of 8. The fill can then reach both the full boundary and each almost threshold within a few hundred cycles. Both clocks run at the same rate with a fixed 3 ns phase offset, so every synchronizer delay is a fixed number of edges. This lets the reference model predict each flag edge by edge. Directed phases then exercise the access decode, overfill and overdrain, and the three-edge release of the full flag. Random traffic runs at write-heavy and read-heavy rates and sweeps the fill through every state.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

    typedef enum logic [1:0] {
        WR_OPEN = 2'd0,
        WR_HIGH = 2'd1,
        WR_FULL = 2'd2
    } wr_lvl_e;

    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_LOW   = 2'd1,
        RD_OPEN  = 2'd2
    } rd_lvl_e;

endpackage

// File: rtl/xdom_ptr_sync.sv
module xdom_ptr_sync #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1_q;
    logic [PW-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        bin_out[PW-1] = stage2_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2_q[i];
        end
    end
endmodule

// File: rtl/xdom_wr_ctrl.sv
module xdom_wr_ctrl
    import xdom_fifo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int ALMOST_OFS = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [PW-1:0] rptr_sync,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          room,
    output logic          almost_full
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HI_MARK  = PW'(DEPTH - ALMOST_OFS);

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] fill;
    wr_lvl_e       st_q;
    wr_lvl_e       st_nxt;

    assign wr_fire  = push_req && (st_q != WR_FULL);
    assign wptr_nxt = wptr_q + PW'(wr_fire);
    assign fill     = wptr_nxt - rptr_sync;
    assign waddr    = wptr_q[AW-1:0];

    // next level from the post-edge fill
    always_comb begin
        if (fill == FULL_CNT) begin
            st_nxt = WR_FULL;
        end else if (fill >= HI_MARK) begin
            st_nxt = WR_HIGH;
        end else begin
            st_nxt = WR_OPEN;
        end
    end

    // state and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WR_OPEN;
            wptr_q <= '0;
            wgray  <= '0;
        end else begin
            st_q   <= st_nxt;
            wptr_q <= wptr_nxt;
            wgray  <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // flag decode
    always_comb begin
        unique case (st_q)
            WR_OPEN: begin
                room        = 1'b1;
                almost_full = 1'b0;
            end
            WR_HIGH: begin
                room        = 1'b1;
                almost_full = 1'b1;
            end
            WR_FULL: begin
                room        = 1'b0;
                almost_full = 1'b1;
            end
            default: begin
                room        = 1'b0;
                almost_full = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xdom_rd_ctrl.sv
module xdom_rd_ctrl
    import xdom_fifo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int ALMOST_OFS = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    input  logic [PW-1:0] wptr_sync,
    output logic          rd_fire,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          avail,
    output logic          almost_empty
);
    localparam logic [PW-1:0] LO_MARK = PW'(ALMOST_OFS);

    logic [PW-1:0] rptr_q;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] fill;
    rd_lvl_e       st_q;
    rd_lvl_e       st_nxt;

    assign rd_fire  = pop_req && (st_q != RD_EMPTY);
    assign rptr_nxt = rptr_q + PW'(rd_fire);
    assign fill     = wptr_sync - rptr_nxt;
    assign raddr    = rptr_q[AW-1:0];

    // next level from the post-edge fill
    always_comb begin
        if (fill == '0) begin
            st_nxt = RD_EMPTY;
        end else if (fill <= LO_MARK) begin
            st_nxt = RD_LOW;
        end else begin
            st_nxt = RD_OPEN;
        end
    end

    // state and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RD_EMPTY;
            rptr_q <= '0;
            rgray  <= '0;
        end else begin
            st_q   <= st_nxt;
            rptr_q <= rptr_nxt;
            rgray  <= rptr_nxt ^ (rptr_nxt >> 1);
        end
    end

    // flag decode
    always_comb begin
        unique case (st_q)
            RD_EMPTY: begin
                avail        = 1'b0;
                almost_empty = 1'b1;
            end
            RD_LOW: begin
                avail        = 1'b1;
                almost_empty = 1'b1;
            end
            RD_OPEN: begin
                avail        = 1'b1;
                almost_empty = 1'b0;
            end
            default: begin
                avail        = 1'b0;
                almost_empty = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xdom_ram.sv
module xdom_ram #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
    parameter int WIDTH      = 36,
    parameter int DEPTH      = 64,
    parameter int ALMOST_OFS = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             a_cs_n,
    input  logic             a_wr,
    input  logic             a_mbx,
    input  logic             a_en,
    input  logic [WIDTH-1:0] a_din,
    output logic             a_room,
    output logic             a_almost_full,
    input  logic             b_cs_n,
    input  logic             b_wr,
    input  logic             b_mbx,
    input  logic             b_en,
    output logic [WIDTH-1:0] b_dout,
    output logic             b_avail,
    output logic             b_almost_empty
);
    logic          push_req;
    logic          pop_req;
    logic          wr_fire;
    logic          rd_fire;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wptr_at_b;
    logic [PW-1:0] rptr_at_a;

    // R1 / R2 access decode
    assign push_req = !a_cs_n && a_wr  && !a_mbx && a_en;
    assign pop_req  = !b_cs_n && !b_wr && !b_mbx && b_en;

    xdom_wr_ctrl #(.DEPTH(DEPTH), .ALMOST_OFS(ALMOST_OFS)) u_wr (
        .clk(clk_a), .rst_n(rst_n), .push_req(push_req), .rptr_sync(rptr_at_a),
        .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
        .room(a_room), .almost_full(a_almost_full)
    );

    xdom_rd_ctrl #(.DEPTH(DEPTH), .ALMOST_OFS(ALMOST_OFS)) u_rd (
        .clk(clk_b), .rst_n(rst_n), .pop_req(pop_req), .wptr_sync(wptr_at_b),
        .rd_fire(rd_fire), .raddr(raddr), .rgray(rgray),
        .avail(b_avail), .almost_empty(b_almost_empty)
    );

    xdom_ptr_sync #(.PW(PW)) u_w2b (
        .clk(clk_b), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_at_b)
    );

    xdom_ptr_sync #(.PW(PW)) u_r2a (
        .clk(clk_a), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_at_a)
    );

    xdom_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .wclk(clk_a), .we(wr_fire), .waddr(waddr), .wdata(a_din),
        .rclk(clk_b), .rst_n(rst_n), .re(rd_fire), .raddr(raddr), .rdata(b_dout)
    );
endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
    parameter int WIDTH = 36,
    parameter int AW    = 6
) (
    input logic             clk_a,
    input logic             clk_b,
    input logic             rst_n,
    input logic             a_room,
    input logic             a_almost_full,
    input logic             b_avail,
    input logic             b_almost_empty,
    input logic             rd_fire,
    input logic [AW-1:0]    waddr,
    input logic [AW-1:0]    raddr,
    input logic [WIDTH-1:0] b_dout
);
    // R8
    no_overflow_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_room |=> $stable(waddr));

    // R9
    no_underflow_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !b_avail |=> $stable(raddr));

    // R7
    dout_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !rd_fire |=> $stable(b_dout));

    // R6
    full_in_band_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_room |-> a_almost_full);

    // R5
    empty_in_band_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !b_avail |-> b_almost_empty);
endmodule

bind xdom_fifo xdom_fifo_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_room(a_room), .a_almost_full(a_almost_full),
    .b_avail(b_avail), .b_almost_empty(b_almost_empty),
    .rd_fire(rd_fire), .waddr(waddr), .raddr(raddr), .b_dout(b_dout)
);

// File: tb/xdom_fifo_bench.sv
module xdom_fifo_bench;
    localparam int W = 36;
    localparam int D = 64;
    localparam int X = 8;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n = 1'b1;
    logic a_cs_n = 1'b1, a_wr = 1'b0, a_mbx = 1'b0, a_en = 1'b0;
    logic [W-1:0] a_din = '0;
    logic b_cs_n = 1'b1, b_wr = 1'b0, b_mbx = 1'b0, b_en = 1'b0;
    logic a_room, a_almost_full, b_avail, b_almost_empty;
    logic [W-1:0] b_dout;

    xdom_fifo #(.WIDTH(W), .DEPTH(D), .ALMOST_OFS(X)) u_xdom_fifo (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_wr(a_wr), .a_mbx(a_mbx), .a_en(a_en), .a_din(a_din),
        .a_room(a_room), .a_almost_full(a_almost_full),
        .b_cs_n(b_cs_n), .b_wr(b_wr), .b_mbx(b_mbx), .b_en(b_en),
        .b_dout(b_dout), .b_avail(b_avail), .b_almost_empty(b_almost_empty)
    );

    // 100 MHz on both sides, port B lagging by 3 ns
    initial forever #5 clk_a = ~clk_a;
    initial begin
        #3;
        forever #5 clk_b = ~clk_b;
    end

    int n_cmp = 0;
    int n_bad = 0;
    bit run_chk = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: counts, synchronizer views, word queue
    int wtot, rtot, rs1, rs2, ws1, ws2, lvl_a, lvl_b;
    logic [W-1:0] q[$];
    logic [W-1:0] dout_m;
    wire a_req = !a_cs_n && a_wr && !a_mbx && a_en;
    wire b_req = !b_cs_n && !b_wr && !b_mbx && b_en;

    always @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) begin
            wtot = 0; rs1 = 0; rs2 = 0; lvl_a = 0;
            q.delete();
        end else begin
            if (a_req && lvl_a != D) begin
                q.push_back(a_din);
                wtot++;
            end
            lvl_a = wtot - rs2;
            rs2 = rs1;
            rs1 = rtot;
        end
    end

    always @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            rtot = 0; ws1 = 0; ws2 = 0; lvl_b = 0; dout_m = '0;
        end else begin
            if (b_req && lvl_b != 0) begin
                dout_m = q.pop_front();
                rtot++;
            end
            lvl_b = ws2 - rtot;
            ws2 = ws1;
            ws1 = wtot;
        end
    end

    always @(negedge clk_a) begin
        if (rst_n && run_chk) begin
            chk("R3 a_room", W'(a_room), W'(lvl_a != D));
            chk("R6 a_almost_full", W'(a_almost_full), W'(lvl_a >= D - X));
        end
    end

    always @(negedge clk_b) begin
        if (rst_n && run_chk) begin
            chk("R4 b_avail", W'(b_avail), W'(lvl_b != 0));
            chk("R5 b_almost_empty", W'(b_almost_empty), W'(lvl_b <= X));
            chk("R7 b_dout", b_dout, dout_m);
        end
    end

    task automatic a_put(input logic cs_n, input logic wr, input logic mbx,
                         input logic en, input logic [W-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_wr = wr; a_mbx = mbx; a_en = en; a_din = d;
    endtask

    task automatic a_idle();
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0;
    endtask

    task automatic b_put(input logic cs_n, input logic wr, input logic mbx, input logic en);
        @(negedge clk_b);
        b_cs_n = cs_n; b_wr = wr; b_mbx = mbx; b_en = en;
    endtask

    task automatic b_idle();
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #1;
        // R10 reset state
        chk("R10 a_room", W'(a_room), W'(1));
        chk("R10 a_almost_full", W'(a_almost_full), W'(0));
        chk("R10 b_avail", W'(b_avail), W'(0));
        chk("R10 b_almost_empty", W'(b_almost_empty), W'(1));
        chk("R10 b_dout", b_dout, '0);
        #30 rst_n = 1'b1;
        run_chk = 1'b1;

        // R1: each wrong qualifier stores nothing
        a_put(1'b1, 1'b1, 1'b0, 1'b1, 36'h111);
        a_put(1'b0, 1'b0, 1'b0, 1'b1, 36'h222);
        a_put(1'b0, 1'b1, 1'b1, 1'b1, 36'h333);
        a_put(1'b0, 1'b1, 1'b0, 1'b0, 36'h444);
        a_idle();
        repeat (6) @(negedge clk_b);
        chk("R1 no store on bad decode", W'(b_avail), W'(0));

        for (int i = 0; i < 3; i++) a_put(1'b0, 1'b1, 1'b0, 1'b1, 36'hA000 + W'(i));
        a_idle();
        repeat (6) @(negedge clk_b);
        chk("R1 store on good decode", W'(b_avail), W'(1));

        // R2: each wrong qualifier reads nothing
        b_put(1'b1, 1'b0, 1'b0, 1'b1);
        b_put(1'b0, 1'b1, 1'b0, 1'b1);
        b_put(1'b0, 1'b0, 1'b1, 1'b1);
        b_put(1'b0, 1'b0, 1'b0, 1'b0);
        b_idle();
        @(negedge clk_b);
        chk("R2 no read on bad decode", b_dout, '0);
        b_put(1'b0, 1'b0, 1'b0, 1'b1);
        b_idle();
        chk("R2 first word read", b_dout, 36'hA000);
        b_put(1'b0, 1'b0, 1'b0, 1'b1);
        b_put(1'b0, 1'b0, 1'b0, 1'b1);
        b_idle();
        repeat (4) @(negedge clk_b);
        chk("R9 drained", W'(b_avail), W'(0));

        // R9: reads while empty ignored
        for (int i = 0; i < 3; i++) b_put(1'b0, 1'b0, 1'b0, 1'b1);
        b_idle();
        @(negedge clk_b);
        chk("R9 dout kept", b_dout, 36'hA002);

        // R8: overfill
        for (int i = 0; i < 70; i++) a_put(1'b0, 1'b1, 1'b0, 1'b1, 36'h50000 + W'(i));
        a_idle();
        repeat (4) @(negedge clk_a);
        chk("R8 full after overfill", W'(a_room), W'(0));

        // R11: one read releases the full flag at the third clk_a edge
        @(negedge clk_b);
        b_cs_n = 1'b0; b_wr = 1'b0; b_mbx = 1'b0; b_en = 1'b1;
        @(posedge clk_b);
        #1 b_en = 1'b0; b_cs_n = 1'b1;
        begin
            int n;
            n = 0;
            while (n < 10 && !a_room) begin
                @(posedge clk_a);
                #2 n++;
            end
            chk("R11 room returns on third clk_a edge", W'(n), W'(3));
        end

        for (int i = 0; i < 70; i++) b_put(1'b0, 1'b0, 1'b0, 1'b1);
        b_idle();
        chk("R8 last kept word", b_dout, 36'h5003F);

        // random traffic, write-heavy then read-heavy
        for (int ph = 0; ph < 2; ph++) begin
            fork
                for (int i = 0; i < 1500; i++) begin
                    a_put(($urandom % 10) == 0, ($urandom % 12) != 0, ($urandom % 12) == 0,
                          ($urandom % 100) < (ph == 0 ? 85 : 35), W'({$urandom, $urandom}));
                end
                for (int i = 0; i < 1500; i++) begin
                    b_put(($urandom % 10) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0,
                          ($urandom % 100) < (ph == 0 ? 35 : 85));
                end
            join
        end
        a_idle();
        for (int i = 0; i < 80; i++) b_put(1'b0, 1'b0, 1'b0, 1'b1);
        b_idle();
        repeat (6) @(negedge clk_b);
        chk("R4 empty at end", W'(b_avail), W'(0));
        finish_run();
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end
endmodule